// File: doc/BRIEF.md
# Byte-ready input port latch

This block captures an 8-bit input port for a CPU. The port sits between a serial byte framer and the processor bus. When latching is on, the port register follows the input pins on every clock. It keeps doing so until an active edge arrives on a control input, which is driven by the framer's byte-ready strobe. That edge freezes the register and raises an interrupt flag.

After that, further control edges are ignored until the CPU reads the port data register. The read clears the flag and returns the register to transparent sampling. Any byte the framer presents between the capture and that read is therefore lost. The first value captured after re-arming is whatever byte is on the pins at that moment.

When latching is off, a data read returns the live pins. The control input passes through a synchronizer. The pin bus is delayed by the same number of stages, so the captured byte is the one that was present when the control edge was first sampled.

Top module: `byte_ready_port_latch`

## Requirements
- R1: After reset the data register (address 0) reads 0, the flag register (address 1) reads 0 and irq_o is low.
- R2: With latching on and the register armed, a data read returns the pins as sampled SYNC_STAGES+1 clocks earlier.
- R3: An active control edge freezes the byte that was on the pins at the clock where the control input was first sampled at its new level. The frozen byte and a high irq_o are visible SYNC_STAGES+1 clocks after that sampling clock.
- R4: While frozen, further control edges and pin changes alter neither the data register nor irq_o.
- R5: A read strobe (rd_i high at a clock edge) at address 0 re-arms sampling and clears irq_o. A read strobe at address 1 leaves the frozen value and irq_o untouched.
- R6: After re-arming, the data register shows the current pins rather than a fixed all-ones value. A byte presented between a capture and the next data read is never captured, and the next edge after the read captures its own byte.
- R7: edge_pol_i = 1 selects rising control edges and 0 selects falling edges. The opposite edge neither captures nor sets irq_o.
- R8: With latch_en_i low, a data read returns pins_i in the same cycle combinationally. An active edge still sets irq_o, and a data read strobe clears it.
- R9: The flag register has irq in bit 0 and "held" (register frozen) in bit 1, with the other bits zero. Addresses 2 and above read zero.
- R10: When a data read strobe and an active edge fall in the same cycle, the capture wins: the byte is frozen, irq_o is high and the held bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | DATA_W | Port input pins |
| ctl_i | input | 1 | Byte-ready control input (asynchronous) |
| latch_en_i | input | 1 | 1 = latch on control edge, 0 = live pins |
| edge_pol_i | input | 1 | 1 = rising edge active, 0 = falling |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | ADDR_W | Register select: 0 data, 1 flags |
| rdata_o | output | DATA_W | Read data for the selected register |
| irq_o | output | 1 | Capture interrupt flag |

## Verification
The bench builds the block with SYNC_STAGES = 3, deeper than the default of 2. This makes the aligned pin delay and the freeze latency long enough that an off-by-one stage error moves a capture onto the wrong byte. It also makes it possible to place a data read exactly in the cycle where the edge detector fires. DATA_W = 8 and ADDR_W = 2 keep the unused addresses 2 and 3 reachable, so the bench can confirm that they read zero.

// File: rtl/port_latch_pkg.sv
package port_latch_pkg;
  localparam int unsigned REG_DATA      = 0;
  localparam int unsigned REG_FLAG      = 1;
  localparam int unsigned FLAG_IRQ_BIT  = 0;
  localparam int unsigned FLAG_HELD_BIT = 1;

  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/ctl_edge_sync.sv
module ctl_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_i,
  input  logic pol_i,
  output logic edge_o
);
  import port_latch_pkg::*;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= ctl_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign level = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level;
  end

  always_comb begin
    if (edge_pol_e'(pol_i) == POL_RISE) edge_o = level & ~prev_q;
    else                                edge_o = ~level & prev_q;
  end
endmodule

// File: rtl/pin_align.sv
module pin_align #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] pins_o
);
  // matches the control synchronizer depth so the captured byte lines up
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= '0;
    else         pipe_q[0] <= pins_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[g] <= '0;
      else         pipe_q[g] <= pipe_q[g-1];
    end
  end

  assign pins_o = pipe_q[STAGES-1];
endmodule

// File: rtl/latch_core.sv
module latch_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         latch_en_i,
  input  logic         edge_i,
  input  logic         rearm_i,
  input  logic [W-1:0] sample_i,
  output logic [W-1:0] hold_o,
  output logic         armed_o,
  output logic         irq_o
);
  logic [W-1:0] hold_q;
  logic         armed_q;
  logic         irq_q;
  logic         open;

  // a data read in the same cycle as an edge still lets the edge capture
  assign open = armed_q | rearm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (!latch_en_i) begin
      hold_q  <= sample_i;
      armed_q <= 1'b1;
      if (edge_i)       irq_q <= 1'b1;
      else if (rearm_i) irq_q <= 1'b0;
    end else if (open) begin
      hold_q  <= sample_i;
      armed_q <= ~edge_i;
      if (edge_i)       irq_q <= 1'b1;
      else if (rearm_i) irq_q <= 1'b0;
    end
  end

  assign hold_o  = hold_q;
  assign armed_o = armed_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/reg_read_mux.sv
module reg_read_mux #(
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              latch_en_i,
  input  logic [W-1:0]      pins_i,
  input  logic [W-1:0]      hold_i,
  input  logic              armed_i,
  input  logic              irq_i,
  output logic [W-1:0]      rdata_o
);
  import port_latch_pkg::*;

  logic [W-1:0] flag_word;

  always_comb begin
    flag_word                = '0;
    flag_word[FLAG_IRQ_BIT]  = irq_i;
    flag_word[FLAG_HELD_BIT] = ~armed_i;
  end

  always_comb begin
    if (addr_i == ADDR_W'(REG_DATA))      rdata_o = latch_en_i ? hold_i : pins_i;
    else if (addr_i == ADDR_W'(REG_FLAG)) rdata_o = flag_word;
    else                                  rdata_o = '0;
  end
endmodule

// File: rtl/byte_ready_port_latch.sv
module byte_ready_port_latch #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pins_i,
  input  logic              ctl_i,
  input  logic              latch_en_i,
  input  logic              edge_pol_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  import port_latch_pkg::*;

  logic [DATA_W-1:0] sample_w;
  logic [DATA_W-1:0] hold_w;
  logic              edge_w;
  logic              armed_w;
  logic              rearm_w;

  assign rearm_w = rd_i & (addr_i == ADDR_W'(REG_DATA));

  ctl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl_i),
    .pol_i  (edge_pol_i),
    .edge_o (edge_w)
  );

  pin_align #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_align (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_i (pins_i),
    .pins_o (sample_w)
  );

  latch_core #(.W(DATA_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .latch_en_i (latch_en_i),
    .edge_i     (edge_w),
    .rearm_i    (rearm_w),
    .sample_i   (sample_w),
    .hold_o     (hold_w),
    .armed_o    (armed_w),
    .irq_o      (irq_o)
  );

  reg_read_mux #(.W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
    .addr_i     (addr_i),
    .latch_en_i (latch_en_i),
    .pins_i     (pins_i),
    .hold_i     (hold_w),
    .armed_i    (armed_w),
    .irq_i      (irq_o),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/byte_ready_port_latch_chk.sv
module byte_ready_port_latch_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              latch_en_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              irq_o,
  input logic              edge_i,
  input logic              armed_i,
  input logic              rearm_i,
  input logic [DATA_W-1:0] hold_i
);
  import port_latch_pkg::*;

  // R3
  capture_freezes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_en_i && armed_i && edge_i) |=> (irq_o && !armed_i));

  // R4
  frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_en_i && !armed_i && !rearm_i) |=> ($stable(hold_i) && !armed_i && $stable(irq_o)));

  // R5
  data_read_rearms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rearm_i && !edge_i) |=> (armed_i && !irq_o));

  // R5
  flag_read_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(REG_FLAG) && latch_en_i && !armed_i) |=> !armed_i);

  // R10
  read_edge_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_en_i && rearm_i && edge_i) |=> (irq_o && !armed_i));
endmodule

bind byte_ready_port_latch byte_ready_port_latch_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .latch_en_i (latch_en_i),
  .rd_i       (rd_i),
  .addr_i     (addr_i),
  .irq_o      (irq_o),
  .edge_i     (edge_w),
  .armed_i    (armed_w),
  .rearm_i    (rearm_w),
  .hold_i     (hold_w)
);

// File: tb/byte_ready_port_latch_tb.sv
module byte_ready_port_latch_tb_top;
  localparam int W = 8;
  localparam int AW = 2;
  localparam int N = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  pins = 8'h5A;
  logic          ctl = 1'b0;
  logic          len = 1'b1;
  logic          pol = 1'b1;
  logic          rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  rdata;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  byte_ready_port_latch #(.DATA_W(W), .ADDR_W(AW), .SYNC_STAGES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .ctl_i(ctl), .latch_en_i(len),
    .edge_pol_i(pol), .rd_i(rd), .addr_i(addr), .rdata_o(rdata), .irq_o(irq)
  );

  // reference model built from the requirements
  logic         m_cp [N];
  logic [W-1:0] m_pp [N];
  logic         m_prev, m_armed, m_irq;
  logic [W-1:0] m_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_cp[i] = 1'b0; m_pp[i] = '0; end
      m_prev = 1'b0; m_armed = 1'b1; m_irq = 1'b0; m_hold = '0;
    end else begin
      logic s, ed, ra;
      logic [W-1:0] smp;
      s   = m_cp[N-1];
      smp = m_pp[N-1];
      ed  = pol ? (s & !m_prev) : (!s & m_prev);
      ra  = rd && (addr == 0);
      if (!len) begin
        m_armed = 1'b1; m_hold = smp;
        if (ed) m_irq = 1'b1; else if (ra) m_irq = 1'b0;
      end else if (m_armed || ra) begin
        m_hold = smp; m_armed = !ed;
        if (ed) m_irq = 1'b1; else if (ra) m_irq = 1'b0;
      end
      m_prev = s;
      for (int i = N-1; i > 0; i--) begin m_cp[i] = m_cp[i-1]; m_pp[i] = m_pp[i-1]; end
      m_cp[0] = ctl; m_pp[0] = pins;
    end
  end

  function automatic logic [W-1:0] model_rdata(logic [AW-1:0] a);
    logic [W-1:0] f;
    f = '0;
    f[0] = m_irq;
    f[1] = !m_armed;
    if (a == 0) return len ? m_hold : pins;
    if (a == 1) return f;
    return '0;
  endfunction

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic peek(string tag, logic [AW-1:0] a, logic [W-1:0] exp);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic check_irq(string tag, logic exp);
    check(tag, {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic strobe(logic [AW-1:0] a);
    addr = a;
    rd = 1'b1;
    tick(1);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1541));
    tick(2);
    // R1 reset state
    peek("R1 data", 0, 8'h00);
    peek("R1 flag", 1, 8'h00);
    check_irq("R1 irq", 1'b0);
    rst_n = 1'b1;

    // R2 transparent lag
    tick(N + 2);
    peek("R2 settle", 0, 8'h5A);
    pins = 8'h3C;
    tick(N);
    peek("R2 before lag", 0, 8'h5A);
    tick(1);
    peek("R2 after lag", 0, 8'h3C);

    // R3 capture
    pins = 8'hC3; ctl = 1'b1;
    tick(1);
    pins = 8'h99;
    tick(N);
    peek("R3 frozen byte", 0, 8'hC3);
    check_irq("R3 irq", 1'b1);
    peek("R9 flag held+irq", 1, 8'h03);

    // R4 later edges ignored
    ctl = 1'b0; pins = 8'h77;
    tick(N + 2);
    ctl = 1'b1;
    tick(N + 2);
    peek("R4 still frozen", 0, 8'hC3);
    check_irq("R4 irq", 1'b1);

    // R5 flag read keeps, data read re-arms
    strobe(1);
    tick(2);
    peek("R5 flag read keeps", 0, 8'hC3);
    strobe(0);
    check_irq("R5 irq cleared", 1'b0);
    peek("R6 resumes pins", 0, 8'h77);
    peek("R5 flag armed", 1, 8'h00);

    // R6 lost byte
    ctl = 1'b0;
    tick(N + 2);
    pins = 8'h21; ctl = 1'b1;
    tick(1);
    pins = 8'h44;
    tick(N + 2);
    ctl = 1'b0;
    tick(N + 2);
    ctl = 1'b1;
    tick(N + 2);
    peek("R6 second byte lost", 0, 8'h21);
    strobe(0);
    peek("R6 current pins", 0, 8'h44);
    pins = 8'h88; ctl = 1'b0;
    tick(N + 2);
    ctl = 1'b1;
    tick(1);
    pins = 8'h11;
    tick(N + 2);
    peek("R6 next edge own byte", 0, 8'h88);

    // R7 falling polarity
    pol = 1'b0;
    strobe(0);
    pins = 8'hA5; ctl = 1'b0;
    tick(1);
    pins = 8'h5B;
    tick(N);
    peek("R7 falling capture", 0, 8'hA5);
    check_irq("R7 falling irq", 1'b1);
    strobe(0);
    ctl = 1'b1;
    tick(N + 2);
    check_irq("R7 rising ignored", 1'b0);
    peek("R7 still transparent", 0, 8'h5B);

    // R10 read and edge in the same cycle
    pol = 1'b1;
    ctl = 1'b0;
    tick(N + 2);
    pins = 8'hE1; ctl = 1'b1;
    tick(N + 2);
    ctl = 1'b0;
    tick(N + 2);
    pins = 8'hE7; ctl = 1'b1;
    tick(N);
    addr = 0; rd = 1'b1;
    tick(1);
    rd = 1'b0;
    pins = 8'h33;
    tick(2);
    peek("R10 capture wins", 0, 8'hE7);
    check_irq("R10 irq", 1'b1);
    peek("R10 held", 1, 8'h03);

    // R8 latch disabled
    len = 1'b0;
    pins = 8'h12;
    peek("R8 live pins", 0, 8'h12);
    pins = 8'h34;
    peek("R8 live pins same cycle", 0, 8'h34);
    strobe(0);
    check_irq("R8 read clears", 1'b0);
    ctl = 1'b0;
    tick(N + 2);
    ctl = 1'b1;
    tick(N + 2);
    check_irq("R8 edge sets irq", 1'b1);
    strobe(0);
    len = 1'b1;
    tick(N + 2);

    // R9 unused addresses
    peek("R9 addr2", 2, 8'h00);
    peek("R9 addr3", 3, 8'h00);

    // random phase against the model
    for (int c = 0; c < 4000; c++) begin
      pins = W'($urandom);
      if ($urandom_range(5) == 0) ctl = ~ctl;
      rd = ($urandom_range(7) == 0);
      addr = AW'($urandom_range(3));
      if ($urandom_range(19) == 0) len = ~len;
      if ($urandom_range(199) == 0) pol = ~pol;
      #1;
      check("R2/R5 random data", rdata, model_rdata(addr));
      check_irq("R3/R4 random irq", m_irq);
      tick(1);
    end
    rd = 1'b0;
    finish_run();
  end
endmodule